// File: doc/BRIEF.md
# Capacitor Ratio Calibration Controller

This controller estimates how far an on-chip capacitor has drifted from its nominal value and sets a small switched compensation bank to cancel the drift. It runs an external relaxation oscillator twice. The first run uses the capacitor under test and the second uses a stable reference capacitor. Over an identical window of clock cycles it counts rising edges of the oscillator output. Because both runs share one oscillator core, the bias, comparator and wiring errors scale both counts alike and drop out of their ratio.

The ratio reference-count / test-count equals C_test / C_ref, which is the normalized process value k of the capacitor under test. A sequential restoring divider computes k as an unsigned fixed-point number with FRAC fraction bits. Seven thresholds derived from the bank geometry turn k into a 3-bit code, which is the number of least-significant compensation units to switch in. Calibration starts by itself when reset is released and starts again on each rising edge of a restart request. While reset is held low, the code output instead shows a value loaded serially from two pins, so the bank can be set by hand.

Top module: `capcal_ctrl`

## Requirements
- R1: While rst_n is low, osc_run, cal_done and div_err are 0. In the cycles after release, bank_code shows the nominal code 3 until a calibration completes.
- R2: A calibration drives osc_run high for WIN_CYC+1 clocks with cap_sel=0, then low for exactly GAP_CYC clocks (GAP_CYC ≥ 2), then high for WIN_CYC+1 clocks with cap_sel=1. cap_sel never changes while osc_run is high.
- R3: Within each run, rising edges of the synchronized osc_in are counted over the window. The counts are ref = edges with cap_sel=1 and test = edges with cap_sel=0.
- R4: The quotient is q = floor(ref·2^FRAC / test) with FRAC=8. With T_n = floor(20000·2^FRAC / (17744 + 379·(2n+1))) for n = 0..6, that is 282, 271, 260, 251, 242, 233 and 225, the code is the number of n for which q < T_n.
- R5: The corners map to the ends of the code range. A slow capacitor (k ≈ 1.15) gives code 0, a nominal one (k = 1.0) gives code 3, and a fast one (k ≈ 0.85) gives code 7.
- R6: If either count is zero, div_err goes to 1, cal_done goes to 1 and bank_code holds the nominal code 3.
- R7: A rising edge on cal_req at any point aborts the current sequence. It clears cal_done and div_err, returns bank_code to 3 and starts a new calibration.
- R8: While rst_n is low, bank_code equals a shift register. On each rising edge of ovr_sclk, the register moves left by one and takes ovr_sdata into bit 0, so the first bit shifted ends up in bit 2.
- R9: Once cal_done is 1, osc_run stays 0 and bank_code holds steady until reset or cal_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also selects the serially loaded code onto bank_code |
| cal_req | input | 1 | Asynchronous restart request, acts on its rising edge |
| osc_in | input | 1 | Asynchronous square wave from the relaxation oscillator |
| ovr_sdata | input | 1 | Serial data for the override code |
| ovr_sclk | input | 1 | Shift clock for the override code, acts on its rising edge |
| osc_run | output | 1 | Lets the oscillator run when high and holds it in its start state when low |
| cap_sel | output | 1 | Oscillator capacitor choice: 0 test, 1 reference |
| bank_code | output | 3 | Number of compensation units switched in |
| cal_done | output | 1 | The code is final |
| div_err | output | 1 | A count was zero and the nominal code was kept |

## Verification
The hardest case to reach is a restart that arrives in the middle of a measurement window: the half-finished run has to leave no trace in the next result. The bench sends a cal_req pulse, waits until the test run is partly done, changes the model oscillator's period to a fast-corner value and sends a second pulse. It then checks that the gap and run lengths start over and that the final code reflects only the new periods. The zero-count path is reached by having the model oscillator stay silent whenever the reference capacitor is selected.

// File: rtl/capcal_pkg.sv
`timescale 1ns/1ps
package capcal_pkg;

   typedef enum logic [2:0] {
      CC_IDLE  = 3'd0,
      CC_RUN_T = 3'd1,
      CC_REST  = 3'd2,
      CC_RUN_R = 3'd3,
      CC_DIV   = 3'd4,
      CC_MAP   = 3'd5,
      CC_DONE  = 3'd6
   } cc_state_t;

   // Boundary between code n and n+1, in q-format with frac fraction bits.
   // base and unit are in units of 1/10000 of the nominal capacitance.
   function automatic int unsigned cc_threshold(input int n, input int frac,
                                                input int base, input int unit);
      longint unsigned num;
      longint unsigned den;
      num = longint'(20000) << frac;
      den = longint'(2 * base + (2 * n + 1) * unit);
      return int'(num / den);
   endfunction

   function automatic int cc_nominal_code(input int levels, input int frac,
                                          input int base, input int unit);
      int c;
      c = 0;
      for (int n = 0; n < levels; n++)
         if ((1 << frac) < cc_threshold(n, frac, base, unit)) c++;
      return c;
   endfunction

endpackage

// File: rtl/capcal_sync.sv
`timescale 1ns/1ps
module capcal_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter bit USE_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("capcal_sync needs at least two stages");
      end
      if (USE_RST) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/capcal_edge_counter.sv
`timescale 1ns/1ps
module capcal_edge_counter #(
   parameter int CNT_W   = 16,
   parameter int WIN_CYC = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             osc_s,
   output logic             win_end,
   output logic [CNT_W-1:0] count
);
   localparam int WIN_W = $clog2(WIN_CYC + 1);

   logic [WIN_W-1:0] win_cnt;
   logic             osc_prev;
   logic             rise;
   logic             in_win;

   assign rise    = osc_s & ~osc_prev;
   assign in_win  = run && (win_cnt < WIN_W'(WIN_CYC));
   assign win_end = run && (win_cnt == WIN_W'(WIN_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         osc_prev <= 1'b0;
         count    <= '0;
      end else begin
         osc_prev <= osc_s;
         if (!run) begin
            win_cnt <= '0;
            count   <= '0;
         end else if (in_win) begin
            win_cnt <= win_cnt + 1'b1;
            if (rise && (count != '1)) count <= count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/capcal_divider.sv
`timescale 1ns/1ps
module capcal_divider #(
   parameter int CNT_W = 16,
   parameter int FRAC  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CNT_W-1:0]      numer,
   input  logic [CNT_W-1:0]      denom,
   output logic                  busy,
   output logic [CNT_W+FRAC-1:0] quot
);
   localparam int Q_W  = CNT_W + FRAC;
   localparam int IT_W = $clog2(Q_W + 1);

   logic [Q_W-1:0]   dvd;
   logic [CNT_W-1:0] dvs;
   logic [CNT_W-1:0] rem;
   logic [IT_W-1:0]  iter;
   logic [CNT_W:0]   trial;
   logic             fits;

   assign trial = {rem, dvd[Q_W-1]};
   assign fits  = trial >= {1'b0, dvs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd  <= '0;
         dvs  <= '0;
         rem  <= '0;
         iter <= '0;
         busy <= 1'b0;
         quot <= '0;
      end else if (start) begin
         dvd  <= {numer, {FRAC{1'b0}}};
         dvs  <= denom;
         rem  <= '0;
         quot <= '0;
         iter <= IT_W'(Q_W);
         busy <= 1'b1;
      end else if (busy) begin
         dvd  <= dvd << 1;
         rem  <= fits ? CNT_W'(trial - {1'b0, dvs}) : trial[CNT_W-1:0];
         quot <= {quot[Q_W-2:0], fits};
         iter <= iter - 1'b1;
         if (iter == IT_W'(1)) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/capcal_codemap.sv
`timescale 1ns/1ps
module capcal_codemap #(
   parameter int Q_W    = 24,
   parameter int FRAC   = 8,
   parameter int CODE_W = 3,
   parameter int BASE   = 8872,
   parameter int UNIT   = 379
) (
   input  logic [Q_W-1:0]    quot,
   output logic [CODE_W-1:0] code
);
   import capcal_pkg::*;

   localparam int LEVELS = (1 << CODE_W) - 1;

   logic [LEVELS-1:0] below;

   generate
      for (genvar n = 0; n < LEVELS; n++) begin : g_thr
         localparam int unsigned THR = cc_threshold(n, FRAC, BASE, UNIT);
         assign below[n] = quot < Q_W'(THR);
      end
   endgenerate

   always_comb begin
      code = '0;
      for (int n = 0; n < LEVELS; n++) code = code + CODE_W'(below[n]);
   end
endmodule

// File: rtl/capcal_override.sv
`timescale 1ns/1ps
module capcal_override #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              sdata,
   input  logic              sclk,
   output logic [CODE_W-1:0] code
);
   logic [1:0] s;
   logic       sclk_prev;

   capcal_sync #(.WIDTH(2), .STAGES(2), .USE_RST(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (1'b1),
      .d     ({sclk, sdata}),
      .q     (s)
   );

   always_ff @(posedge clk) begin
      sclk_prev <= s[1];
      if (s[1] && !sclk_prev) code <= {code[CODE_W-2:0], s[0]};
   end
endmodule

// File: rtl/capcal_ctrl.sv
`timescale 1ns/1ps
module capcal_ctrl #(
   parameter int CNT_W   = 16,
   parameter int FRAC    = 8,
   parameter int WIN_CYC = 4096,
   parameter int GAP_CYC = 2,
   parameter int CODE_W  = 3,
   parameter int BASE    = 8872,
   parameter int UNIT    = 379
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_req,
   input  logic              osc_in,
   input  logic              ovr_sdata,
   input  logic              ovr_sclk,
   output logic              osc_run,
   output logic              cap_sel,
   output logic [CODE_W-1:0] bank_code,
   output logic              cal_done,
   output logic              div_err
);
   import capcal_pkg::*;

   localparam int Q_W      = CNT_W + FRAC;
   localparam int GAP_W    = $clog2(GAP_CYC + 1);
   localparam int LEVELS   = (1 << CODE_W) - 1;
   localparam int NOM_CODE = cc_nominal_code(LEVELS, FRAC, BASE, UNIT);

   generate
      if (GAP_CYC < 2) begin : g_gap_chk
         $error("GAP_CYC must be at least 2");
      end
      if ($clog2(WIN_CYC) > CNT_W) begin : g_cnt_chk
         $error("CNT_W too narrow for WIN_CYC");
      end
      if (CODE_W < 2) begin : g_code_chk
         $error("CODE_W must be at least 2");
      end
   endgenerate

   cc_state_t        state;
   logic [GAP_W-1:0] gap_cnt;
   logic [CNT_W-1:0] cnt_test_q;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] map_code;
   logic [CODE_W-1:0] ovr_code;
   logic [1:0]       in_s;
   logic             cal_prev;
   logic             cal_rise;
   logic             run;
   logic             win_end;
   logic [CNT_W-1:0] count;
   logic             div_start;
   logic             div_busy;
   logic [Q_W-1:0]   quot;
   logic             zero_cnt;

   capcal_sync #(.WIDTH(2), .STAGES(2), .USE_RST(1'b1)) u_in_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cal_req, osc_in}),
      .q     (in_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal_prev <= 1'b0;
      else        cal_prev <= in_s[1];
   end
   assign cal_rise = in_s[1] & ~cal_prev;

   assign run     = (state == CC_RUN_T) || (state == CC_RUN_R);
   assign osc_run = run;
   assign cap_sel = (state == CC_REST) || (state == CC_RUN_R);

   capcal_edge_counter #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .osc_s   (in_s[0]),
      .win_end (win_end),
      .count   (count)
   );

   assign zero_cnt  = (count == '0) || (cnt_test_q == '0);
   assign div_start = (state == CC_RUN_R) && win_end && !zero_cnt && !cal_rise;

   capcal_divider #(.CNT_W(CNT_W), .FRAC(FRAC)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .numer (count),
      .denom (cnt_test_q),
      .busy  (div_busy),
      .quot  (quot)
   );

   capcal_codemap #(.Q_W(Q_W), .FRAC(FRAC), .CODE_W(CODE_W),
                    .BASE(BASE), .UNIT(UNIT)) u_map (
      .quot (quot),
      .code (map_code)
   );

   capcal_override #(.CODE_W(CODE_W)) u_ovr (
      .clk   (clk),
      .sdata (ovr_sdata),
      .sclk  (ovr_sclk),
      .code  (ovr_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= CC_IDLE;
         gap_cnt    <= '0;
         cnt_test_q <= '0;
         code_q     <= CODE_W'(NOM_CODE);
         cal_done   <= 1'b0;
         div_err    <= 1'b0;
      end else if (cal_rise) begin
         state    <= CC_IDLE;
         gap_cnt  <= '0;
         code_q   <= CODE_W'(NOM_CODE);
         cal_done <= 1'b0;
         div_err  <= 1'b0;
      end else begin
         unique case (state)
            CC_IDLE, CC_REST: begin
               if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                  gap_cnt <= '0;
                  state   <= (state == CC_IDLE) ? CC_RUN_T : CC_RUN_R;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            CC_RUN_T: begin
               if (win_end) begin
                  cnt_test_q <= count;
                  state      <= CC_REST;
               end
            end
            CC_RUN_R: begin
               if (win_end) begin
                  if (zero_cnt) begin
                     div_err  <= 1'b1;
                     cal_done <= 1'b1;
                     code_q   <= CODE_W'(NOM_CODE);
                     state    <= CC_DONE;
                  end else begin
                     state <= CC_DIV;
                  end
               end
            end
            CC_DIV: begin
               if (!div_busy) state <= CC_MAP;
            end
            CC_MAP: begin
               code_q   <= map_code;
               cal_done <= 1'b1;
               state    <= CC_DONE;
            end
            default: state <= CC_DONE;
         endcase
      end
   end

   assign bank_code = rst_n ? code_q : ovr_code;

endmodule

// File: rtl/capcal_ctrl_chk.sv
`timescale 1ns/1ps
module capcal_ctrl_chk #(
   parameter int CODE_W   = 3,
   parameter int NOM_CODE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              osc_run,
   input logic              cap_sel,
   input logic [CODE_W-1:0] bank_code,
   input logic              cal_done,
   input logic              div_err
);
   AST_SEL_STABLE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_run && $past(osc_run)) |-> $stable(cap_sel)); // R2
   AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_run) |=> !osc_run); // R2
   AST_DONE_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> !osc_run); // R9
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && $past(cal_done)) |-> $stable(bank_code)); // R9
   AST_ERR_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |-> (bank_code == CODE_W'(NOM_CODE))); // R6
   AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |-> cal_done); // R6
endmodule

bind capcal_ctrl capcal_ctrl_chk #(.CODE_W(CODE_W), .NOM_CODE(NOM_CODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_run   (osc_run),
   .cap_sel   (cap_sel),
   .bank_code (bank_code),
   .cal_done  (cal_done),
   .div_err   (div_err)
);

// File: tb/capcal_ctrl_bench.sv
`timescale 1ns/1ps
module capcal_ctrl_bench;
   localparam int WIN = 4096;
   localparam int GAP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cal_req = 1'b0;
   logic       osc_in = 1'b0;
   logic       ovr_sdata = 1'b0;
   logic       ovr_sclk = 1'b0;
   logic       osc_run;
   logic       cap_sel;
   logic [2:0] bank_code;
   logic       cal_done;
   logic       div_err;

   int  checks = 0;
   int  errors = 0;
   int  cycles = 0;
   real half_t = 20.0;
   real half_r = 20.0;
   logic kill_ref = 1'b0;

   capcal_ctrl #(.WIN_CYC(WIN), .GAP_CYC(GAP)) u_capcal_ctrl (
      .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .osc_in(osc_in),
      .ovr_sdata(ovr_sdata), .ovr_sclk(ovr_sclk), .osc_run(osc_run),
      .cap_sel(cap_sel), .bank_code(bank_code), .cal_done(cal_done),
      .div_err(div_err)
   );

   always #4 clk = ~clk;

   // oscillator model: held low while stopped, free-running otherwise
   always begin
      if (!osc_run || (cap_sel && kill_ref)) begin
         osc_in = 1'b0;
         @(negedge clk);
      end else begin
         #(cap_sel ? half_r : half_t);
         osc_in = ~osc_in;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected code per R4, computed from the stated thresholds
   function automatic int exp_code(input real ratio);
      int t [7] = '{282, 271, 260, 251, 242, 233, 225};
      int q;
      int c;
      q = int'($floor(ratio * 256.0));
      c = 0;
      for (int n = 0; n < 7; n++) if (q < t[n]) c++;
      return c;
   endfunction

   task automatic pulse_cal();
      @(negedge clk);
      cal_req = 1'b1;
      tick(2);
      cal_req = 1'b0;
      tick(4);
   endtask

   // watch one calibration and return the stretch lengths
   task automatic watch_run(output int t_len, output int g_len, output int r_len,
                            output bit order_ok);
      int phase = 0;
      t_len = 0; g_len = 0; r_len = 0; order_ok = 1'b1;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         case (phase)
            0: if (osc_run) begin
                  if (cap_sel) order_ok = 1'b0;
                  t_len = 1; phase = 1;
               end
            1: if (osc_run) t_len++; else begin g_len = 1; phase = 2; end
            2: if (!osc_run) g_len++;
               else begin
                  if (!cap_sel) order_ok = 1'b0;
                  r_len = 1; phase = 3;
               end
            default: if (osc_run) r_len++;
         endcase
         if (phase == 3 && cal_done) break;
      end
   endtask

   task automatic t_ratio(input string req, input real p_test, input real p_ref);
      int tl, gl, rl;
      bit ok;
      int e;
      half_t = p_test / 2.0;
      half_r = p_ref / 2.0;
      pulse_cal();
      watch_run(tl, gl, rl, ok);
      e = exp_code(p_test / p_ref);
      check(cal_done == 1'b1, {req, " done"}, cal_done, 1);
      check(bank_code == 3'(e), {req, " code (R4)"}, bank_code, e);
      check(div_err == 1'b0, {req, " no error"}, div_err, 0);
      check(tl == WIN + 1 && rl == WIN + 1, "R2 run length", tl, WIN + 1);
      check(gl == GAP, "R2 gap length", gl, GAP);
      check(ok, "R2 capacitor order", ok, 1);
   endtask

   task automatic t_override();
      bit bits [3] = '{1'b1, 1'b1, 1'b0};
      for (int i = 0; i < 3; i++) begin
         ovr_sdata = bits[i]; tick(4);
         ovr_sclk = 1'b1; tick(4);
         ovr_sclk = 1'b0; tick(4);
      end
      check(bank_code == 3'b110, "R8 override 110", bank_code, 6);
      bits = '{1'b0, 1'b0, 1'b1};
      for (int i = 0; i < 3; i++) begin
         ovr_sdata = bits[i]; tick(4);
         ovr_sclk = 1'b1; tick(4);
         ovr_sclk = 1'b0; tick(4);
      end
      check(bank_code == 3'b001, "R8 override 001", bank_code, 1);
   endtask

   task automatic t_reset();
      check(osc_run == 1'b0 && cal_done == 1'b0 && div_err == 1'b0,
            "R1 outputs in reset", {osc_run, cal_done, div_err}, 0);
      rst_n = 1'b1;
      tick(1);
      check(bank_code == 3'd3, "R1 nominal code after reset", bank_code, 3);
      check(cal_done == 1'b0, "R1 not done after reset", cal_done, 0);
   endtask

   task automatic t_zero_ref();
      int tl, gl, rl;
      bit ok;
      kill_ref = 1'b1;
      half_t = 23.0;
      pulse_cal();
      watch_run(tl, gl, rl, ok);
      tick(2);
      check(div_err == 1'b1, "R6 error flag", div_err, 1);
      check(bank_code == 3'd3, "R6 nominal code", bank_code, 3);
      check(cal_done == 1'b1, "R6 done", cal_done, 1);
      kill_ref = 1'b0;
   endtask

   task automatic t_hold();
      logic [2:0] keep;
      bit bad = 1'b0;
      keep = bank_code;
      half_t = 11.0;
      half_r = 30.0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (osc_run || bank_code != keep || !cal_done) bad = 1'b1;
      end
      check(!bad, "R9 code held and oscillator off", bank_code, keep);
   endtask

   task automatic t_restart();
      int tl, gl, rl;
      bit ok;
      half_t = 23.0; half_r = 20.0;
      pulse_cal();
      check(cal_done == 1'b0, "R7 done cleared", cal_done, 0);
      check(bank_code == 3'd3, "R7 code back to nominal", bank_code, 3);
      tick(2000);
      check(osc_run == 1'b1, "R7 mid-run", osc_run, 1);
      half_t = 17.0;
      pulse_cal();
      watch_run(tl, gl, rl, ok);
      check(bank_code == 3'd7, "R7 code after restart", bank_code, 7);
      check(tl == WIN + 1 && gl == GAP, "R7 restart run length", tl, WIN + 1);
   endtask

   initial begin
      tick(3);
      t_override();
      t_reset();
      t_ratio("R5 nominal", 40.0, 40.0);
      t_ratio("R5 slow", 46.0, 40.0);
      t_ratio("R5 fast", 34.0, 40.0);
      t_ratio("R3 mid high", 41.6, 40.0);
      t_ratio("R3 mid low", 37.2, 40.0);
      t_ratio("R4 near slow", 43.2, 40.0);
      t_hold();
      t_zero_ref();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule